// File: doc/BRIEF.md
# Sync-Framed Word Serializer

This block is the transmit side of a byte-framed serial link. A host loads a parallel word through a valid/ready handshake. The block sends the word as a serial bit stream, one bit per clock. Ahead of every data byte it inserts a single timing bit, which a receiver uses to re-clock the stream. Each byte therefore takes nine bit slots, and the line rate is 9/8 of the payload rate. The timing bits are removed at the far end, so the payload arrives unchanged.

A mode input sets the word length for each transfer: 32 bits (four bytes, 36 slots) or 16 bits (two bytes, 18 slots). The mode is sampled together with the word, so the frame length can change from one word to the next. Between words the block lowers its output enable, which releases the shared line for other nodes. A one-cycle done pulse marks the end of each word.

Top module: `sync_serializer`

## Requirements
- R1: While in reset and directly after reset, `load_ready_o` is 1 and `ser_oe_o`, `ser_data_o` and `done_o` are 0.
- R2: A word is accepted at a rising clock edge where `load_valid_i` and `load_ready_o` are both 1. `load_ready_o` is 0 from the next cycle until every slot of that word has been sent.
- R3: Each byte takes 9 consecutive slots. Slot 0 of each byte is a sync bit of constant value 1.
- R4: Slots 1 to 8 of a byte carry its data bits MSB first, and bytes go most significant first. The payload rebuilt from the data slots equals the loaded word.
- R5: With `mode_wide_i`=1 at acceptance, all 32 bits are sent in 36 slots. With `mode_wide_i`=0, only `load_data_i[15:0]` is sent, in 18 slots.
- R6: `ser_oe_o` is 1 exactly during the slots of a word. The first slot is the cycle after acceptance, and `ser_oe_o` falls one cycle after the last data bit. `ser_data_o` is 0 whenever `ser_oe_o` is 0.
- R7: `done_o` is a single-cycle pulse in the cycle after the last data bit, which is the same cycle in which `ser_oe_o` falls.
- R8: `load_data_i` and `load_valid_i` have no effect on the serial output while a word is being sent.
- R9: Changing `mode_wide_i` while a word is being sent does not change that word's length or content.
- R10: A word offered in the done cycle is accepted there, and its first sync slot follows in the next cycle, with no extra idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_valid_i | input | 1 | Host offers a word |
| load_data_i | input | 32 | Word to send |
| mode_wide_i | input | 1 | 1: 32-bit word, 0: 16-bit word (low half) |
| load_ready_o | output | 1 | Block can accept a word |
| ser_data_o | output | 1 | Serial line data |
| ser_oe_o | output | 1 | Line driver enable; 0 releases the bus |
| done_o | output | 1 | One-cycle pulse after a word's last bit |

## Verification
Slot 0 of a frame appears one cycle after the accepting edge. Slot i appears i cycles after that. The done pulse and the fall of output enable come N cycles after slot 0, where N is 18 or 36. The bench drives at falling edges and samples each slot at the falling edge of its own cycle, so every check lands in the cycle in which the requirement places the result. The bench sweeps walking-one, walking-zero and mixed words in both modes. It also corrupts the data, valid and mode inputs during frames and sends words back to back.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SLOT_PER = BYTE_W + 1;

  typedef enum logic {
    MODE_HALF = 1'b0,
    MODE_FULL = 1'b1
  } mode_e;
endpackage

// File: rtl/ser_slot_ctr.sv
module ser_slot_ctr #(
  parameter int unsigned NBYTES = 4,
  localparam int unsigned BI_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int unsigned SL_W  = $clog2(ser_pkg::SLOT_PER)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            run_i,
  input  logic [BI_W-1:0] last_byte_i,
  output logic            sync_slot_o,
  output logic            last_slot_o
);
  localparam logic [SL_W-1:0] SLOT_LAST = SL_W'(ser_pkg::SLOT_PER - 1);

  logic [SL_W-1:0] slot_q;
  logic [BI_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      byte_q <= '0;
    end else if (start_i) begin
      slot_q <= '0;
      byte_q <= '0;
    end else if (run_i) begin
      if (slot_q == SLOT_LAST) begin
        slot_q <= '0;
        byte_q <= byte_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign sync_slot_o = (slot_q == '0);
  assign last_slot_o = run_i && (slot_q == SLOT_LAST) && (byte_q == last_byte_i);

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SLOT_LAST); // R3
  AST_SLOT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i && slot_q == SLOT_LAST) |=> (slot_q == '0)); // R3
endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              shift_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= load_data_i;
    else if (shift_i) sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
  end

  assign msb_o = sreg_q[WORD_W-1];

  AST_SHIFT_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (msb_o == $past(sreg_q[WORD_W-2]))); // R4
endmodule

// File: rtl/sync_serializer.sv
module sync_serializer #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned NBYTES = WORD_W / ser_pkg::BYTE_W,
  localparam int unsigned BI_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int unsigned RUN_W  = $clog2(NBYTES * ser_pkg::SLOT_PER + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_valid_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              mode_wide_i,
  output logic              load_ready_o,
  output logic              ser_data_o,
  output logic              ser_oe_o,
  output logic              done_o
);
  import ser_pkg::*;

  localparam logic [BI_W-1:0]  LAST_FULL = BI_W'(NBYTES - 1);
  localparam logic [BI_W-1:0]  LAST_HALF = BI_W'(NBYTES / 2 - 1);
  localparam logic [RUN_W-1:0] RUN_FULL  = RUN_W'(NBYTES * SLOT_PER);
  localparam logic [RUN_W-1:0] RUN_HALF  = RUN_W'(NBYTES / 2 * SLOT_PER);

  logic              busy_q, done_q;
  mode_e             mode_q;
  logic              accept, sync_slot, last_slot, msb;
  logic [WORD_W-1:0] aligned;
  logic [BI_W-1:0]   last_byte;

  assign accept = load_valid_i && !busy_q;

  // half words are left-aligned so both modes leave from the MSB
  assign aligned = mode_wide_i ? load_data_i
                               : {load_data_i[HALF_W-1:0], {HALF_W{1'b0}}};
  assign last_byte = (mode_q == MODE_FULL) ? LAST_FULL : LAST_HALF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= MODE_HALF;
    end else begin
      done_q <= busy_q && last_slot;
      if (accept) begin
        busy_q <= 1'b1;
        mode_q <= mode_e'(mode_wide_i);
      end else if (last_slot) begin
        busy_q <= 1'b0;
      end
    end
  end

  ser_slot_ctr #(.NBYTES(NBYTES)) i_slot_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .run_i       (busy_q),
    .last_byte_i (last_byte),
    .sync_slot_o (sync_slot),
    .last_slot_o (last_slot)
  );

  ser_shift_reg #(.WORD_W(WORD_W)) i_shift_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_data_i (aligned),
    .shift_i     (busy_q && !sync_slot),
    .msb_o       (msb)
  );

  assign load_ready_o = !busy_q;
  assign ser_oe_o     = busy_q;
  assign ser_data_o   = busy_q && (sync_slot || msb);
  assign done_o       = done_q;

  // frame length tracker for checking only
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (accept) run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
  end

  AST_FIRST_SLOT_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_oe_o) |-> ser_data_o); // R3
  AST_DONE_AT_OE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_oe_o) |-> done_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_NO_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_oe_o |-> !load_ready_o); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_oe_o |-> !ser_data_o); // R6
  AST_FRAME_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_oe_o) |-> (run_q == ((mode_q == MODE_FULL) ? RUN_FULL : RUN_HALF))); // R5
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_oe_o && !$rose(ser_oe_o)) |-> $stable(mode_q)); // R9
endmodule

// File: tb/test_sync_serializer.sv
module test_sync_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] data = '0;
  logic        wide = 1'b0;
  logic        ready, sdata, oe, done;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  sync_serializer i_sync_serializer (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .load_valid_i (valid),
    .load_data_i  (data),
    .mode_wide_i  (wide),
    .load_ready_o (ready),
    .ser_data_o   (sdata),
    .ser_oe_o     (oe),
    .done_o       (done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the falling edge of the done cycle
  task automatic send(input logic [31:0] w, input logic m, input bit noisy);
    int nb;
    logic [31:0] rebuilt;
    logic [31:0] word;
    nb = m ? 32 : 16;
    word = m ? w : {16'h0, w[15:0]};
    rebuilt = '0;
    valid = 1'b1; data = w; wide = m;
    chk("R2 ready before accept", 32'(ready), 32'd1);
    @(negedge clk);
    if (noisy) begin
      valid = 1'b1; data = ~w; wide = ~m;   // R8 R9 disturbance
    end else valid = 1'b0;
    for (int i = 0; i < nb / 8 * 9; i++) begin
      int b, s;
      logic e;
      b = i / 9; s = i % 9;
      e = (s == 0) ? 1'b1 : word[nb - 1 - b * 8 - (s - 1)];
      chk("R6 oe during frame", 32'(oe), 32'd1);
      chk("R2 ready low while busy", 32'(ready), 32'd0);
      if (s == 0) chk("R3 sync bit", 32'(sdata), 32'd1);
      else begin
        chk(noisy ? "R8 R9 data slot under noise" : "R4 R5 data slot", 32'(sdata), 32'(e));
        rebuilt = {rebuilt[30:0], sdata};
      end
      if (noisy) data = data ^ 32'(i * 32'h9e37_79b9);
      @(negedge clk);
    end
    chk("R4 payload rebuilt", rebuilt, word);
    chk("R6 oe falls after last bit", 32'(oe), 32'd0);
    chk("R7 done pulse", 32'(done), 32'd1);
    chk("R2 ready back", 32'(ready), 32'd1);
    chk("R6 data quiet", 32'(sdata), 32'd0);
    valid = 1'b0;
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R7 done single cycle", 32'(done), 32'd0);
    chk("R6 oe idle", 32'(oe), 32'd0);
    chk("R6 data idle", 32'(sdata), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(ready), 32'd1);
    chk("R1 oe in reset", 32'(oe), 32'd0);
    chk("R1 data in reset", 32'(sdata), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(ready), 32'd1);
    chk("R1 oe after reset", 32'(oe), 32'd0);
    // walking patterns in both modes
    for (int k = 0; k < 32; k++) begin
      for (int m = 0; m < 2; m++) begin
        send(32'h1 << k, m[0], 1'b0); idle_check();
        send(~(32'h1 << k), m[0], 1'b0); idle_check();
      end
    end
    // mixed words with noise on the inputs during frames (R8, R9)
    for (int k = 0; k < 16; k++) begin
      send(32'ha5c3_0f96 ^ (32'h0101_0101 * k), k[0], 1'b1); idle_check();
    end
    // back-to-back: offer next word in the done cycle (R10)
    send(32'hdead_beef, 1'b1, 1'b0);
    send(32'h1234_8e71, 1'b0, 1'b0);
    send(32'h0f0f_c3c3, 1'b1, 1'b0);
    idle_check();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule